// File: doc/BRIEF.md
# Shared-Vector Pin Interrupt Aggregator

This block turns edge events on a group of general-purpose input pins into one interrupt request line. Every pin can be enabled on its own and has its own polarity. A pin with positive polarity fires on a rising edge and is active while high. A pin with negative polarity fires on a falling edge and is active while low. Edges from enabled pins are ORed into a single request flip-flop. A global enable masks that flip-flop's effect on the output, and an acknowledge pulse clears it. The output does not identify the pin that fired, and no pin has priority over another.

After a pin fires, it owns a lockout. No other pin can raise a request until the owning pin goes back to its inactive level or its enable is cleared. The acknowledge clears only the request, not the lockout or any enable. A host-port mode hands the output to an external request (`hp_req_i`). That request is gated only by the global enable. In this mode all pin requests are blocked, whatever the per-pin enables say.

Configuration uses a write-only register port. The enable mask is at address 0x00, the polarity mask at 0x01 (1 = positive), and the control register at 0x20. In the control register, bit 5 is the global enable and bit 0 is host-port mode.

Top module: `pin_irq_agg`

## Requirements
- R1: After reset, `irq_o` is 0, and all enables, polarities, the global enable, host mode, the request and the lockout are cleared, so pin edges cause no request until software configures the block.
- R2: A pin with polarity bit 1 and enable bit 1 sets the request on a rising edge at the pin. With the global enable set, `irq_o` is high no later than the fourth clock after the pin change. A falling edge on such a pin sets nothing.
- R3: A pin with polarity bit 0 and enable bit 1 sets the request on a falling edge. A rising edge sets nothing.
- R4: A pin whose enable bit is 0 never sets the request.
- R5: After a pin has set the request, edges on any other pin set nothing until the owning pin returns to its inactive level. Only one pin owns the lockout at a time.
- R6: Clearing the owning pin's enable bit also releases the lockout, so another enabled pin's edge can then set the request.
- R7: A one-cycle `ack_i` pulse clears the request, so `irq_o` falls. It changes no enable bit, so a later edge on the same pin, after re-arming, sets the request again.
- R8: `irq_o` equals the request ANDed with control bit 5. Clearing bit 5 masks a pending request without discarding it, and setting bit 5 again shows it.
- R9: With control bit 0 set, `irq_o` equals `hp_req_i` AND control bit 5. Pin edges set no request in this mode, including on enabled pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| pin_i | input | N_PINS | Asynchronous pin inputs |
| ack_i | input | 1 | Interrupt acknowledge pulse |
| hp_req_i | input | 1 | Host-port request used in host mode |
| irq_o | output | 1 | Shared interrupt request |

## Verification
The bench uses the default build: eight pins, eight data bits and a two-stage synchronizer. With eight pins, one pin can own the lockout while a second pin tries to fire and a third pin is left disabled, all within one configuration. The two-stage depth sets the latency from a pin change to the output at three clocks, and the checks are timed to that latency.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] A_EN   = 6'h00;
  localparam logic [ADDR_W-1:0] A_POL  = 6'h01;
  localparam logic [ADDR_W-1:0] A_CTRL = 6'h20;
  localparam int GIE_BIT  = 5;
  localparam int HOST_BIT = 0;
endpackage

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int N_PINS = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [N_PINS-1:0] en_o,
  output logic [N_PINS-1:0] pol_o,
  output logic              gie_o,
  output logic              host_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      pol_o  <= '0;
      gie_o  <= 1'b0;
      host_o <= 1'b0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        A_EN:   en_o  <= wr_data_i[N_PINS-1:0];
        A_POL:  pol_o <= wr_data_i[N_PINS-1:0];
        A_CTRL: begin
          gie_o  <= wr_data_i[GIE_BIT];
          host_o <= wr_data_i[HOST_BIT];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic pol_i,
  output logic lvl_o,
  output logic edge_o
);
  localparam int LAST = STAGES - 1;
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign lvl_o = sh_q[LAST];
  // compare against raw previous level so a polarity write cannot fake an edge
  assign edge_o = pol_i ? ( sh_q[LAST] & ~sh_q[STAGES])
                        : (~sh_q[LAST] &  sh_q[STAGES]);
endmodule

// File: rtl/pin_irq_core.sv
module pin_irq_core #(
  parameter int N_PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] edge_i,
  input  logic [N_PINS-1:0] lvl_i,
  input  logic [N_PINS-1:0] en_i,
  input  logic [N_PINS-1:0] pol_i,
  input  logic              host_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [N_PINS-1:0] owner_o,
  output logic              set_o
);
  logic [N_PINS-1:0] active, qual, pick, owner_n;
  logic              locked, release_c, lock_free, req_n;

  assign active    = ~(lvl_i ^ pol_i);
  assign locked    = |owner_o;
  assign release_c = |(owner_o & (~active | ~en_i));
  assign lock_free = ~locked | release_c;
  assign qual      = host_i ? '0 : (edge_i & en_i);
  assign pick      = qual & (~qual + 1'b1);  // lowest set bit, arbitrary owner
  assign set_o     = lock_free & (|qual);

  always_comb begin
    owner_n = owner_o;
    if (set_o)          owner_n = pick;
    else if (release_c) owner_n = '0;
    req_n = req_o;
    if (ack_i) req_n = 1'b0;
    if (set_o) req_n = 1'b1;  // new event outranks a same-cycle ack
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o   <= 1'b0;
      owner_o <= '0;
    end else begin
      req_o   <= req_n;
      owner_o <= owner_n;
    end
  end
endmodule

// File: rtl/pin_irq_agg.sv
module pin_irq_agg
  import pin_irq_pkg::*;
#(
  parameter int N_PINS      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [N_PINS-1:0] pin_i,
  input  logic              ack_i,
  input  logic              hp_req_i,
  output logic              irq_o
);
  logic [N_PINS-1:0] en_q, pol_q, lvl_vec, edge_vec, owner_q;
  logic              gie_q, host_q, req_q, set_c;

  pin_irq_regs #(.N_PINS(N_PINS), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .en_o(en_q), .pol_o(pol_q), .gie_o(gie_q), .host_o(host_q)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    pin_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i, .rst_ni, .pin_i(pin_i[i]), .pol_i(pol_q[i]),
      .lvl_o(lvl_vec[i]), .edge_o(edge_vec[i])
    );
  end

  pin_irq_core #(.N_PINS(N_PINS)) u_core (
    .clk_i, .rst_ni, .edge_i(edge_vec), .lvl_i(lvl_vec), .en_i(en_q),
    .pol_i(pol_q), .host_i(host_q), .ack_i, .req_o(req_q),
    .owner_o(owner_q), .set_o(set_c)
  );

  assign irq_o = gie_q & (host_q ? hp_req_i : req_q);
endmodule

// File: rtl/pin_irq_agg_chk.sv
module pin_irq_agg_chk
  import pin_irq_pkg::*;
#(
  parameter int N_PINS = 8,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              ack_i,
  input logic              hp_req_i,
  input logic              irq_o,
  input logic [N_PINS-1:0] en,
  input logic [N_PINS-1:0] edge_vec,
  input logic [N_PINS-1:0] owner,
  input logic              req,
  input logic              host,
  input logic              set
);
  a_r8_gie_off_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_CTRL && !wr_data_i[GIE_BIT]) |=> !irq_o);
  a_r9_host_blocks_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host |-> !set);
  a_r9_host_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host && !hp_req_i) |-> !irq_o);
  a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !set) |=> !req);
  a_r7_ack_keeps_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !wr_en_i) |=> $stable(en));
  a_r4_needs_enabled_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req) |-> |$past(edge_vec & en));
  a_r5_single_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(owner));
  a_r5_lock_with_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req) |-> (|owner));
endmodule

bind pin_irq_agg pin_irq_agg_chk #(.N_PINS(N_PINS), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .ack_i(ack_i), .hp_req_i(hp_req_i), .irq_o(irq_o),
  .en(en_q), .edge_vec(edge_vec), .owner(owner_q), .req(req_q),
  .host(host_q), .set(set_c)
);

// File: tb/pin_irq_agg_tb.sv
module pin_irq_agg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_PINS = 8;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en = 1'b0;
  logic [5:0]        wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [N_PINS-1:0] pin = '0;
  logic              ack = 1'b0;
  logic              hp_req = 1'b0;
  logic              irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_irq_agg #(.N_PINS(N_PINS), .DATA_W(DATA_W), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pin_i(pin), .ack_i(ack), .hp_req_i(hp_req),
    .irq_o(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic exp);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s: irq_o=%b expected=%b", req, irq, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [DATA_W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0;
    tick(1);
  endtask

  task automatic set_pin(input int i, input logic v);
    pin[i] = v;
    tick(4);
  endtask

  task automatic do_ack();
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
    tick(1);
  endtask

  task automatic t_reset();
    check("R1 reset", 1'b0);
    set_pin(0, 1'b1);
    check("R1 unconfigured edge", 1'b0);
    set_pin(0, 1'b0);
  endtask

  task automatic t_rise();
    wr(6'h00, 8'h01); wr(6'h01, 8'h09); wr(6'h20, 8'h20);
    set_pin(0, 1'b1);
    check("R2 rising edge", 1'b1);
    do_ack();
    check("R7 ack clears", 1'b0);
    set_pin(0, 1'b0);
    check("R2 falling ignored", 1'b0);
  endtask

  task automatic t_fall();
    wr(6'h00, 8'h02);
    set_pin(1, 1'b1);
    check("R3 rising ignored", 1'b0);
    set_pin(1, 1'b0);
    check("R3 falling edge", 1'b1);
    do_ack();
    set_pin(1, 1'b1);
  endtask

  task automatic t_disabled();
    wr(6'h01, 8'h0D); wr(6'h00, 8'h09);
    set_pin(2, 1'b1);
    check("R4 disabled pin", 1'b0);
    set_pin(2, 1'b0);
  endtask

  task automatic t_lock();
    set_pin(0, 1'b1);
    check("R5 owner fires", 1'b1);
    do_ack();
    set_pin(3, 1'b1);
    check("R5 locked out", 1'b0);
    set_pin(3, 1'b0);
    set_pin(0, 1'b0);
    set_pin(3, 1'b1);
    check("R5 after release", 1'b1);
    do_ack();
    set_pin(3, 1'b0);
  endtask

  task automatic t_en_clear();
    set_pin(0, 1'b1);
    do_ack();
    wr(6'h00, 8'h08);
    set_pin(3, 1'b1);
    check("R6 enable clear releases", 1'b1);
    do_ack();
    set_pin(3, 1'b0);
    set_pin(0, 1'b0);
    wr(6'h00, 8'h09);
  endtask

  task automatic t_survive();
    set_pin(0, 1'b1);
    do_ack();
    set_pin(0, 1'b0);
    set_pin(0, 1'b1);
    check("R7 enable survives ack", 1'b1);
    do_ack();
    set_pin(0, 1'b0);
  endtask

  task automatic t_gie();
    wr(6'h20, 8'h00);
    set_pin(0, 1'b1);
    check("R8 masked", 1'b0);
    wr(6'h20, 8'h20);
    check("R8 pending kept", 1'b1);
    do_ack();
    set_pin(0, 1'b0);
  endtask

  task automatic t_host();
    wr(6'h20, 8'h21);
    hp_req = 1'b1; tick(1);
    check("R9 host request", 1'b1);
    hp_req = 1'b0; tick(1);
    check("R9 host idle", 1'b0);
    set_pin(0, 1'b1);
    check("R9 pin blocked", 1'b0);
    wr(6'h20, 8'h01);
    hp_req = 1'b1; tick(1);
    check("R9 host gated by gie", 1'b0);
    hp_req = 1'b0;
    wr(6'h20, 8'h20);
    check("R9 no pin capture in host", 1'b0);
    set_pin(0, 1'b0);
  endtask

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(2);
    t_reset();
    t_rise();
    t_fall();
    t_disabled();
    t_lock();
    t_en_clear();
    t_survive();
    t_gie();
    t_host();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule